// File: doc/BRIEF.md
# Serial flash command responder

This block is the slave-side command engine of a serial flash emulator. It watches a four-wire serial bus (serial clock, active-low select, data in, data out), collects an 8-bit opcode from the first eight serial clock periods of each selection, and then answers the identification and status commands. A status-register write is accepted only when it directly follows an enabling command. Unknown opcodes are ignored until the host deselects the device.

The serial inputs are sampled in the block's own system clock domain. Data in is taken on each detected rising edge of the serial clock. Data out is updated on each detected falling edge, most significant bit first. The data-out pin comes with a separate output-enable flag. That flag is low whenever no reply bit is being presented. Any deselection ends the current command. Only the protection bits, the write-enable latch and the write-permission flag carry over from one selection to the next.

Top module: `sfl_cmd_responder`

## Requirements
- R1: After reset, `sout_oe` is low and the status byte reads 00h.
- R2: `sout_oe` is low while `cs_n` is high, and during the opcode, dummy and address bytes of every command.
- R3: Opcode 9Fh returns 8Ch, 20h, 16h, most significant bit first, and repeats that three-byte group for as long as the clock runs.
- R4: Opcode 90h takes two don't-care bytes and then an address byte. If bit 0 of the address byte is 0, the reply is 8Ch, 15h repeated.
- R5: For opcode 90h with address bit 0 equal to 1, the pair order is reversed: 15h, 8Ch repeated.
- R6: Opcode 05h returns the status byte over and over. Bits 7:2 hold the protection field, bit 1 the write-enable latch, and bit 0 is always 0.
- R7: Opcode 06h sets the write-enable latch (status bit 1).
- R8: Opcode 01h, when the command directly before it was 06h or 50h, loads bits 7:2 of the following data byte into the protection field and clears the write-enable latch. Data bits 1:0 are discarded.
- R9: Opcode 01h that does not directly follow 06h or 50h changes nothing in the status byte.
- R10: Raising `cs_n` at any bit abandons the command in progress. A status write cut short before its eighth data bit has no effect, and the next selection decodes a fresh opcode.
- R11: An unsupported opcode gives no output until deselection, and it cancels any pending status-write permission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low device select |
| sin | input | 1 | Serial data from the host |
| sout | output | 1 | Serial reply data |
| sout_oe | output | 1 | High while `sout` carries a valid reply bit |

## Verification
The assertions assume that `sclk`, `cs_n` and `sin` are already synchronous to `clk`. They also assume each serial clock phase lasts several system clocks, so that every serial edge is seen as exactly one rise or fall event. The bench keeps every serial clock phase four system clocks long. It changes `sin` only while `sclk` is low, and it moves `cs_n` only with `sclk` low and with idle system clocks on either side.

// File: rtl/sfl_pkg.sv
`timescale 1ns/1ps
package sfl_pkg;

  localparam logic [7:0] OP_JEDEC_ID  = 8'h9F;
  localparam logic [7:0] OP_PAIR_ID   = 8'h90;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_ST_EN  = 8'h50;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_HEADER,
    ST_WDATA,
    ST_SEND,
    ST_IGNORE
  } sfl_state_e;

  typedef enum logic [1:0] {
    SRC_JEDEC,
    SRC_PAIR,
    SRC_STATUS
  } sfl_src_e;

endpackage

// File: rtl/sfl_edge_detect.sv
`timescale 1ns/1ps
module sfl_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;

endmodule

// File: rtl/sfl_cmd_decode.sv
`timescale 1ns/1ps
module sfl_cmd_decode
  import sfl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DUMMY_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sin,
  input  logic              wr_perm,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_op,
  output logic              wr_go,
  output logic [DATA_W-3:0] wr_prot,
  output logic              send_en,
  output sfl_src_e          src,
  output logic              swap
);

  localparam int HDR_BITS = DATA_W * (DUMMY_BYTES + 1);
  localparam int CNT_W    = $clog2(HDR_BITS + 1);

  sfl_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, sh_nxt;
  sfl_src_e          src_q, src_d;
  logic              swap_q, swap_d;

  assign sh_nxt = {sh_q[DATA_W-2:0], sin};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    src_d     = src_q;
    swap_d    = swap_q;
    cmd_valid = 1'b0;
    wr_go     = 1'b0;
    if (cs_n) begin
      state_d = ST_OPCODE;
      cnt_d   = '0;
    end else if (sclk_rise) begin
      sh_d = sh_nxt;
      case (state_q)
        ST_OPCODE: begin
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_d     = '0;
            cmd_valid = 1'b1;
            case (sh_nxt)
              OP_JEDEC_ID: begin
                state_d = ST_SEND;
                src_d   = SRC_JEDEC;
              end
              OP_RD_STATUS: begin
                state_d = ST_SEND;
                src_d   = SRC_STATUS;
              end
              OP_PAIR_ID:   state_d = ST_HEADER;
              OP_WR_STATUS: state_d = wr_perm ? ST_WDATA : ST_IGNORE;
              default:      state_d = ST_IGNORE;
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HEADER: begin
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            cnt_d   = '0;
            state_d = ST_SEND;
            src_d   = SRC_PAIR;
            swap_d  = sin;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WDATA: begin
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_d   = '0;
            wr_go   = 1'b1;
            state_d = ST_IGNORE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;
      cnt_q   <= '0;
      sh_q    <= '0;
      src_q   <= SRC_STATUS;
      swap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      src_q   <= src_d;
      swap_q  <= swap_d;
    end
  end

  assign cmd_op  = sh_nxt;
  assign wr_prot = sh_nxt[DATA_W-1:2];
  assign send_en = (state_q == ST_SEND);
  assign src     = src_q;
  assign swap    = swap_q;

endmodule

// File: rtl/sfl_status_reg.sv
`timescale 1ns/1ps
module sfl_status_reg
  import sfl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_op,
  input  logic              wr_go,
  input  logic [DATA_W-3:0] wr_prot,
  output logic              wr_perm,
  output logic [DATA_W-1:0] st_byte
);

  localparam int PROT_W = DATA_W - 2;

  logic [PROT_W-1:0] prot_q, prot_d;
  logic              wel_q, wel_d;
  logic              perm_q, perm_d;

  always_comb begin
    prot_d = prot_q;
    wel_d  = wel_q;
    perm_d = perm_q;
    if (cmd_valid) begin
      perm_d = (cmd_op == OP_WR_EN) || (cmd_op == OP_WR_ST_EN);
      if (cmd_op == OP_WR_EN) wel_d = 1'b1;
    end
    if (wr_go) begin
      prot_d = wr_prot;
      wel_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      wel_q  <= 1'b0;
      perm_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
      wel_q  <= wel_d;
      perm_q <= perm_d;
    end
  end

  assign wr_perm = perm_q;
  assign st_byte = {prot_q, wel_q, 1'b0};

endmodule

// File: rtl/sfl_out_shifter.sv
`timescale 1ns/1ps
module sfl_out_shifter
  import sfl_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID  = 8'h8C,
  parameter logic [DATA_W-1:0] TYPE_ID = 8'h20,
  parameter logic [DATA_W-1:0] CAP_ID  = 8'h16,
  parameter logic [DATA_W-1:0] DEV_ID  = 8'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk_fall,
  input  logic              send_en,
  input  sfl_src_e          src,
  input  logic              swap,
  input  logic [DATA_W-1:0] st_byte,
  output logic              sout,
  output logic              sout_oe
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d, byte_sel;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [1:0]        idx_q, idx_d;
  logic              out_q, out_d;
  logic              oe_q, oe_d;
  logic              last_idx;

  always_comb begin
    case (src)
      SRC_JEDEC:  byte_sel = (idx_q == 2'd0) ? MFR_ID :
                             (idx_q == 2'd1) ? TYPE_ID : CAP_ID;
      SRC_PAIR:   byte_sel = (idx_q[0] ^ swap) ? DEV_ID : MFR_ID;
      default:    byte_sel = st_byte;
    endcase
  end

  assign last_idx = (src == SRC_JEDEC) ? (idx_q == 2'd2) : (idx_q == 2'd1);

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    idx_d = idx_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (cs_n) begin
      bit_d = '0;
      idx_d = '0;
      oe_d  = 1'b0;
    end else if (sclk_fall && send_en) begin
      oe_d = 1'b1;
      if (bit_q == '0) begin
        out_d = byte_sel[DATA_W-1];
        sh_d  = {byte_sel[DATA_W-2:0], 1'b0};
      end else begin
        out_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      end
      if (bit_q == BIT_W'(DATA_W - 1)) begin
        bit_d = '0;
        idx_d = last_idx ? 2'd0 : idx_q + 2'd1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
      idx_q <= '0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign sout    = out_q;
  assign sout_oe = oe_q & ~cs_n;

endmodule

// File: rtl/sfl_cmd_responder.sv
`timescale 1ns/1ps
module sfl_cmd_responder
  import sfl_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                DUMMY_BYTES = 2,
  parameter logic [DATA_W-1:0] MFR_ID      = 8'h8C,
  parameter logic [DATA_W-1:0] TYPE_ID     = 8'h20,
  parameter logic [DATA_W-1:0] CAP_ID      = 8'h16,
  parameter logic [DATA_W-1:0] DEV_ID      = 8'h15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sin,
  output logic sout,
  output logic sout_oe
);

  logic              sclk_rise, sclk_fall;
  logic              cmd_valid, wr_go, wr_perm, send_en, swap;
  logic [DATA_W-1:0] cmd_op, st_byte;
  logic [DATA_W-3:0] wr_prot;
  sfl_src_e          src;

  sfl_edge_detect edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  sfl_cmd_decode #(
    .DATA_W      (DATA_W),
    .DUMMY_BYTES (DUMMY_BYTES)
  ) dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sin       (sin),
    .wr_perm   (wr_perm),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wr_go     (wr_go),
    .wr_prot   (wr_prot),
    .send_en   (send_en),
    .src       (src),
    .swap      (swap)
  );

  sfl_status_reg #(
    .DATA_W (DATA_W)
  ) st_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wr_go     (wr_go),
    .wr_prot   (wr_prot),
    .wr_perm   (wr_perm),
    .st_byte   (st_byte)
  );

  sfl_out_shifter #(
    .DATA_W  (DATA_W),
    .MFR_ID  (MFR_ID),
    .TYPE_ID (TYPE_ID),
    .CAP_ID  (CAP_ID),
    .DEV_ID  (DEV_ID)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_fall (sclk_fall),
    .send_en   (send_en),
    .src       (src),
    .swap      (swap),
    .st_byte   (st_byte),
    .sout      (sout),
    .sout_oe   (sout_oe)
  );

endmodule

// File: rtl/sfl_cmd_checker.sv
`timescale 1ns/1ps
module sfl_cmd_checker
  import sfl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sout_oe,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] cmd_op,
  input logic              wr_go,
  input logic              wr_perm,
  input logic [DATA_W-1:0] st_byte
);

  p_oe_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sout_oe);

  p_oe_quiet_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !sout_oe);

  p_wel_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR_EN) |=> st_byte[1]);

  p_wel_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !st_byte[1]);

  p_prot_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(st_byte[DATA_W-1:2]));

  p_perm_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_WR_EN && cmd_op != OP_WR_ST_EN) |=> !wr_perm);

  p_bit0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_byte[0]);

endmodule

bind sfl_cmd_responder sfl_cmd_checker #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sout_oe   (sout_oe),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wr_go     (wr_go),
  .wr_perm   (wr_perm),
  .st_byte   (st_byte)
);

// File: tb/sfl_cmd_responder_tb.sv
`timescale 1ns/1ps
module sfl_cmd_responder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sin = 1'b0;
  logic sout, sout_oe;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] d;
    logic       oe;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] rx_d;
  logic       rx_all, rx_any;
  event       byte_done;

  always #2 clk = ~clk;

  sfl_cmd_responder dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sin     (sin),
    .sout    (sout),
    .sout_oe (sout_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic so, output logic oe);
    sin = b;
    wait_clk(4);
    so = sout;
    oe = sout_oe;
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [7:0] tx, input logic exp_oe,
                      input logic [7:0] exp_d, input string tag);
    exp_t it;
    logic so, oe;
    logic [7:0] d;
    logic all, any;
    it.d = exp_d;
    it.oe = exp_oe;
    it.tag = tag;
    exp_q.push_back(it);
    all = 1'b1;
    any = 1'b0;
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(tx[i], so, oe);
      d[i] = so;
      all = all & oe;
      any = any | oe;
    end
    rx_d = d;
    rx_all = all;
    rx_any = any;
    -> byte_done;
    wait_clk(1);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n);
    logic so, oe;
    for (int i = 7; i > 7 - n; i--) bit_xfer(tx[i], so, oe);
  endtask

  task automatic sel;
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(6);
    chk(sout_oe == 1'b0, "R2 oe low while deselected", {7'd0, sout_oe}, 8'h00);
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    sel();
    send(8'h05, 1'b0, 8'h00, "R2 status opcode quiet");
    send(8'h00, 1'b1, exp, tag);
    desel();
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(byte_done);
      it = exp_q.pop_front();
      checks++;
      if (it.oe) begin
        if (!(rx_all && rx_d == it.d)) begin
          fails++;
          $display("FAIL %s: got %h oe %b, expected %h oe 1", it.tag, rx_d, rx_all, it.d);
        end
      end else if (rx_any) begin
        fails++;
        $display("FAIL %s: got oe 1, expected oe 0", it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stimulus
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk(sout_oe == 1'b0, "R1 oe low after reset", {7'd0, sout_oe}, 8'h00);
    read_status(8'h00, "R1 status after reset");

    sel();
    send(8'h9F, 1'b0, 8'h00, "R2 jedec opcode quiet");
    send(8'h00, 1'b1, 8'h8C, "R3 jedec byte 0");
    send(8'h00, 1'b1, 8'h20, "R3 jedec byte 1");
    send(8'h00, 1'b1, 8'h16, "R3 jedec byte 2");
    send(8'h00, 1'b1, 8'h8C, "R3 jedec wraps");
    desel();

    sel();
    send(8'h90, 1'b0, 8'h00, "R2 pair opcode quiet");
    send(8'h00, 1'b0, 8'h00, "R2 dummy 0 quiet");
    send(8'h00, 1'b0, 8'h00, "R2 dummy 1 quiet");
    send(8'h00, 1'b0, 8'h00, "R2 address quiet");
    send(8'h00, 1'b1, 8'h8C, "R4 pair first");
    send(8'h00, 1'b1, 8'h15, "R4 pair second");
    send(8'h00, 1'b1, 8'h8C, "R4 pair repeat");
    send(8'h00, 1'b1, 8'h15, "R4 pair repeat second");
    desel();

    sel();
    send(8'h90, 1'b0, 8'h00, "R2 pair opcode quiet");
    send(8'hFF, 1'b0, 8'h00, "R2 dummy 0 quiet");
    send(8'hFF, 1'b0, 8'h00, "R2 dummy 1 quiet");
    send(8'h01, 1'b0, 8'h00, "R2 address quiet");
    send(8'h00, 1'b1, 8'h15, "R5 swapped first");
    send(8'h00, 1'b1, 8'h8C, "R5 swapped second");
    send(8'h00, 1'b1, 8'h15, "R5 swapped repeat");
    desel();

    sel(); send(8'h06, 1'b0, 8'h00, "R7 enable quiet"); desel();
    read_status(8'h02, "R7 latch set");

    sel(); send(8'h06, 1'b0, 8'h00, "R8 enable quiet"); desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R8 write opcode quiet");
    send(8'hAF, 1'b0, 8'h00, "R8 write data quiet"); desel();
    read_status(8'hAC, "R8 write after 06");

    sel(); send(8'h50, 1'b0, 8'h00, "R8 status enable quiet"); desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R8 write opcode quiet");
    send(8'h57, 1'b0, 8'h00, "R8 write data quiet"); desel();
    read_status(8'h54, "R8 write after 50");

    sel(); send(8'h06, 1'b0, 8'h00, "R9 enable quiet"); desel();
    sel();
    send(8'h05, 1'b0, 8'h00, "R2 status opcode quiet");
    send(8'h00, 1'b1, 8'h56, "R6 status repeat 0");
    send(8'h00, 1'b1, 8'h56, "R6 status repeat 1");
    send(8'h00, 1'b1, 8'h56, "R6 status repeat 2");
    desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R9 write opcode quiet");
    send(8'hFF, 1'b0, 8'h00, "R9 write data quiet"); desel();
    read_status(8'h56, "R9 blocked write");

    sel(); send(8'h06, 1'b0, 8'h00, "R11 enable quiet"); desel();
    sel();
    send(8'hAB, 1'b0, 8'h00, "R11 unknown opcode quiet");
    send(8'h00, 1'b0, 8'h00, "R11 ignored 0");
    send(8'hFF, 1'b0, 8'h00, "R11 ignored 1");
    send(8'h00, 1'b0, 8'h00, "R11 ignored 2");
    desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R11 write opcode quiet");
    send(8'h00, 1'b0, 8'h00, "R11 write data quiet"); desel();
    read_status(8'h56, "R11 permission cancelled");

    sel(); send(8'h06, 1'b0, 8'h00, "R10 enable quiet"); desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R10 write opcode quiet");
    send_bits(8'h00, 4); desel();
    read_status(8'h56, "R10 short write ignored");

    sel(); send_bits(8'h9F, 5); desel();
    sel();
    send(8'h9F, 1'b0, 8'h00, "R10 fresh opcode quiet");
    send(8'h00, 1'b1, 8'h8C, "R10 fresh decode");
    desel();

    sel(); send(8'h50, 1'b0, 8'h00, "R8 status enable quiet"); desel();
    sel(); send(8'h01, 1'b0, 8'h00, "R8 write opcode quiet");
    send(8'h03, 1'b0, 8'h00, "R8 write data quiet"); desel();
    read_status(8'h00, "R8 latch cleared by write");

    wait_clk(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule